// File: doc/BRIEF.md
# Pin-to-Level Interrupt Steering Unit

This block steers eight external, level-sensitive interrupt pins onto the processor's system interrupt levels. Each pin owns a 4-bit selector field. A nonzero legal field value names the level that the pin drives. The routed levels are ORed together, a per-level mask is applied, and the result goes out as a 16-bit pending vector. A priority encoder beside the processor consumes that vector.

Software programs the steering through a small register port. Two 16-bit select registers each hold four pin fields. The mask is never written directly: one write port sets mask bits and another clears them, and a 1 in the written data marks the bit to change. Because the interrupts are level-sensitive, nothing is latched. The pending vector tracks the pins combinationally from one moment to the next.

Top module: `irq_steer_top`

## Requirements
- R1: After reset both select registers read 0, every level is masked, and `irq_pending` is 0 whatever the pins do.
- R2: A write to address 0 loads the select register for pins 0 to 3, and a write to address 1 loads the one for pins 4 to 7. Each reads back at the same address. Reads of addresses 2 and 3 return 0.
- R3: The field for pin p sits at bits [4*(p mod 4)+3 : 4*(p mod 4)] of its select register. A field affects no other pin.
- R4: A field value v with 1 <= v <= 14 drives pending bit v while the pin is high and level v is unmasked.
- R5: A write to address 2 masks every level whose data bit is 1. Levels whose data bit is 0 keep their state.
- R6: A write to address 3 unmasks every level whose data bit is 1. Levels whose data bit is 0 keep their state.
- R7: `irq_pending` equals the routed levels ANDed with the inverted mask. It follows pin changes without any clock edge and holds no memory of a past request.
- R8: Field values 0 and 15 route the pin nowhere. Pending bits 0 and 15 are always 0.
- R9: When several pins select the same level, that level is pending if any one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address: 0 select low, 1 select high, 2 mask set, 3 mask clear |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 16 | Read data (select registers, 0 otherwise) |
| irq_pins | input | 8 | External level-sensitive interrupt pins |
| irq_pending | output | 16 | Unmasked pending levels, one bit per level |

## Verification
The bench builds the block with its default parameters: eight pins, 4-bit fields and sixteen levels. At that size every field value can be tried on every pin, and every one of the 256 pin patterns can be applied. The bench therefore sweeps all 128 pin/value pairs, checking both that the selected level appears and that the other pins stay silent. It then walks set and clear over each routed level, and drives all pin patterns with pins sharing a level and with a partial mask. All of this is checked against an arithmetic model of field extraction and masking.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int ADDR_W = 2;

  // A field value routes only when it is neither the "off" code 0
  // nor the reserved top code (levels - 1).
  function automatic logic lvl_legal(input int unsigned value,
                                     input int unsigned levels);
    return (value != 0) && (value < levels - 1);
  endfunction

  // Number of select registers needed for a pin count.
  function automatic int unsigned regs_needed(input int unsigned pins,
                                              input int unsigned per_reg);
    return (pins + per_reg - 1) / per_reg;
  endfunction

endpackage

// File: rtl/irq_sel_bank.sv
module irq_sel_bank #(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS-1:0]       wr_stb,
  input  logic [REG_W-1:0]          wr_data,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);

  logic [REG_W-1:0] sel_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[r] <= '0;
      else if (wr_stb[r])
        sel_q[r] <= wr_data;
    end

    assign regs_flat[r*REG_W +: REG_W] = sel_q[r];

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb[r] |=> (regs_flat[r*REG_W +: REG_W] == $past(wr_data)));

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb[r] |=> $stable(regs_flat[r*REG_W +: REG_W]));
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [LEVELS-1:0] bits,
  output logic [LEVELS-1:0] mask
);

  logic [LEVELS-1:0] mask_q;
  logic [LEVELS-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_stb) mask_d = mask_d | bits;
    if (clr_stb) mask_d = mask_d & ~bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '1;
    else
      mask_q <= mask_d;
  end

  assign mask = mask_q;

  assert_set_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ((mask & $past(bits)) == $past(bits)));

  assert_set_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ((mask & ~$past(bits)) == ($past(mask) & ~$past(bits))));

  assert_clr_unmasks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((mask & $past(bits)) == '0));

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(mask));

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_steer_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 4,
  parameter int LEVELS   = 16,
  parameter int FLAT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] regs_flat,
  input  logic [NUM_PINS-1:0] pins,
  output logic [LEVELS-1:0] routed
);

  logic [SEL_W-1:0]    pin_field [NUM_PINS];
  logic [NUM_PINS-1:0] pin_hit;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_field[p] = regs_flat[p*SEL_W +: SEL_W];
    assign pin_hit[p]   = pins[p] && lvl_legal(int'(pin_field[p]), LEVELS);

    assert_pin_routes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_hit[p] |-> routed[pin_field[p]]);
  end

  always_comb begin
    routed = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int l = 0; l < LEVELS; l++) begin
        if (pin_hit[p] && (pin_field[p] == SEL_W'(l)))
          routed[l] = 1'b1;
      end
    end
  end

  assert_edges_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !routed[0] && !routed[LEVELS-1]);

  assert_no_pins_no_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == '0) |-> (routed == '0));

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 4,
  parameter int REG_W    = 16,
  parameter int LEVELS   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_waddr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic [ADDR_W-1:0]   reg_raddr,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] irq_pins,
  output logic [LEVELS-1:0]   irq_pending
);

  localparam int PER_REG  = REG_W / SEL_W;
  localparam int NUM_REGS = regs_needed(NUM_PINS, PER_REG);
  localparam int FLAT_W   = NUM_REGS * REG_W;
  localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_REGS + 1);

  logic [NUM_REGS-1:0] sel_stb;
  logic                set_stb;
  logic                clr_stb;
  logic [FLAT_W-1:0]   regs_flat;
  logic [LEVELS-1:0]   mask;
  logic [LEVELS-1:0]   routed;

  always_comb begin
    sel_stb = '0;
    for (int r = 0; r < NUM_REGS; r++)
      sel_stb[r] = reg_wr && (reg_waddr == ADDR_W'(r));
  end

  assign set_stb = reg_wr && (reg_waddr == SET_ADDR);
  assign clr_stb = reg_wr && (reg_waddr == CLR_ADDR);

  irq_sel_bank #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (sel_stb),
    .wr_data  (reg_wdata),
    .regs_flat(regs_flat)
  );

  irq_mask_reg #(.LEVELS(LEVELS)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_stb(set_stb),
    .clr_stb(clr_stb),
    .bits   (reg_wdata[LEVELS-1:0]),
    .mask   (mask)
  );

  irq_level_map #(
    .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .LEVELS(LEVELS), .FLAT_W(FLAT_W)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .regs_flat(regs_flat),
    .pins     (irq_pins),
    .routed   (routed)
  );

  assign irq_pending = routed & ~mask;

  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (reg_raddr == ADDR_W'(r))
        reg_rdata = regs_flat[r*REG_W +: REG_W];
  end

  assert_pending_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending & mask) == '0);

  assert_pending_from_routed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending & ~routed) == '0);

  assert_reset_masked_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_pending == '0));

endmodule

// File: tb/irq_steer_top_test.sv
module irq_steer_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  irq_pins = '0;
  logic [15:0] irq_pending;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_lo = '0, m_hi = '0, m_mask = 16'hFFFF;

  always #5 clk = ~clk;

  irq_steer_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq_pins(irq_pins), .irq_pending(irq_pending)
  );

  function automatic logic [15:0] model(input logic [15:0] lo, input logic [15:0] hi,
                                        input logic [7:0] pins, input logic [15:0] msk);
    int unsigned e = 0;
    for (int p = 0; p < 8; p++) begin
      int unsigned r = (p < 4) ? lo : hi;
      int unsigned v = (r / (2 ** (4 * (p % 4)))) % 16;
      if (pins[p] && v >= 1 && v <= 14) e = e | (2 ** v);
    end
    return 16'(e) & ~msk;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      2'd0: m_lo = d;
      2'd1: m_hi = d;
      2'd2: m_mask = m_mask | d;
      default: m_mask = m_mask & ~d;
    endcase
  endtask

  task automatic pend_chk(input string req);
    #1;
    chk(req, irq_pending, model(m_lo, m_hi, irq_pins, m_mask));
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    reg_raddr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    irq_pins = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd_chk("R1 sel lo", 2'd0, 16'h0);
    rd_chk("R1 sel hi", 2'd1, 16'h0);
    chk("R1 pending", irq_pending, 16'h0);
    wr(2'd0, 16'h4321); wr(2'd1, 16'hE765);
    pend_chk("R1 all masked");
    chk("R1 masked routed", irq_pending, 16'h0);
    // R2: readback and unused read addresses
    rd_chk("R2 lo", 2'd0, 16'h4321);
    rd_chk("R2 hi", 2'd1, 16'hE765);
    rd_chk("R2 addr2", 2'd2, 16'h0);
    rd_chk("R2 addr3", 2'd3, 16'h0);

    wr(2'd3, 16'hFFFF);
    // R3/R4/R8: every pin, every value
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 16; v++) begin
        logic [15:0] f;
        f = 16'(v) << (4 * (p % 4));
        wr(2'd0, (p < 4) ? f : 16'h0);
        wr(2'd1, (p < 4) ? 16'h0 : f);
        rd_chk("R2 sweep", (p < 4) ? 2'd0 : 2'd1, f);
        irq_pins = 8'(1 << p);
        pend_chk((v == 0 || v == 15) ? "R8 unrouted" : "R4 route");
        chk("R8 edge bits", irq_pending & 16'h8001, 16'h0);
        irq_pins = ~(8'(1 << p));
        pend_chk("R3 field isolation");
      end
    end

    // R5/R6: mask set and clear per level
    wr(2'd0, 16'h4321); wr(2'd1, 16'h8765);
    irq_pins = 8'hFF;
    pend_chk("R6 all unmasked");
    for (int l = 1; l <= 8; l++) begin
      wr(2'd2, 16'(1 << l));
      pend_chk("R5 set one level");
      wr(2'd2, 16'h0);
      pend_chk("R5 zero data no change");
      wr(2'd3, 16'(1 << l));
      pend_chk("R6 clear one level");
    end
    wr(2'd2, 16'h00AA);
    wr(2'd3, 16'h0);
    pend_chk("R6 zero data no change");

    // R7: pending follows pins, no latching
    for (int pat = 0; pat < 256; pat++) begin
      @(negedge clk);
      irq_pins = 8'(pat);
      pend_chk("R7 partial mask pattern");
      irq_pins = 8'h00;
      pend_chk("R7 release no latch");
    end

    // R9: shared level ORed
    wr(2'd3, 16'hFFFF);
    wr(2'd0, 16'h5555); wr(2'd1, 16'h5555);
    for (int pat = 0; pat < 256; pat++) begin
      @(negedge clk);
      irq_pins = 8'(pat);
      pend_chk("R9 shared level");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule